// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter with Background Selection

This block decides which of several bus initiators owns a shared parallel bus next. Each initiator has a private request input and a private grant output. The arbiter watches the two shared transaction-control signals, the frame signal and the initiator-ready signal, to follow bus activity. It can pick and grant the next owner while another initiator is still moving data. The granted initiator then starts its own transaction once the bus goes idle. A grant covers one transaction: when the new owner starts, its grant is taken away, and a master that wants another transaction must win again.

Selection is round-robin. The search starts at the index after the last initiator that actually started a transaction and wraps past the highest index. A steady requester therefore waits for at most N-1 other transactions. Moving the grant from one initiator to another always passes through at least one clock with every grant low. A grant is withdrawn when its holder stops requesting before it starts. With no requests pending, the arbiter holds all grants low. All control signals here are active high: the bus is idle in a cycle where frame and ready are both low.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with no requests present, every bit of `gnt_o` is 0.
- R2: At most one bit of `gnt_o` is 1 on any clock.
- R3: A grant bit is 1 only if the matching bit of `req_i` was 1 at the preceding rising clock edge.
- R4: If `req_i` is all zero at a rising edge, `gnt_o` is all zero after that edge.
- R5: When the grants are all low and requests are pending, the next grant goes to the first requester found when searching upward from the index after the last initiator that started a transaction, wrapping from N-1 to 0. After reset, the last starter is taken to be N-1, so index 0 is searched first.
- R6: A grant can be issued while another transaction is in progress (`frame_i` or `irdy_i` high).
- R7: A transaction start is a clock in which `frame_i` is 1 and the previous clock had both `frame_i` and `irdy_i` at 0. If a start occurs while a grant is held, that grant drops to 0 after the same edge, and the holder becomes the last starter.
- R8: After an initiator starts a transaction, another pending requester is granted before that same initiator is granted again.
- R9: If the holder's request bit is 0 at an edge while it holds a grant that has not yet been used, the grant drops to 0 after that edge, and the last starter is left unchanged.
- R10: Between two consecutive nonzero values of `gnt_o` that differ, at least one clock with `gnt_o` all zero occurs.
- R11: A rise of `frame_i` directly after a clock with `irdy_i` high and `frame_i` low is not a start, so the grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_INIT | Per-initiator bus request, bit i for initiator i |
| frame_i | input | 1 | Shared frame signal, 1 while a transaction's address or non-final data phases run |
| irdy_i | input | 1 | Shared initiator-ready signal, 1 during a data phase |
| gnt_o | output | N_INIT | Per-initiator one-hot grant |

## Verification
Every decision is registered, so a wrong internal value appears at the grant outputs within one clock. A stale or corrupted last-starter index shows up at the next arbitration as a grant to the wrong requester, and the bench's round-robin sequence exposes it. A lost idle flag shows up as a grant that stays high after a legal start, or one that falls after an illegal frame rise. A wrong phase shows up as two different masters granted back to back with no all-low clock between them.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        PH_OPEN = 1'b0,   // no grant outstanding, arbitration runs
        PH_HELD = 1'b1    // one grant outstanding, waiting for its start
    } arb_phase_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N_INIT = 4,
    parameter int IDXW   = (N_INIT > 1) ? $clog2(N_INIT) : 1
) (
    input  logic [N_INIT-1:0] req_i,
    input  logic [IDXW-1:0]   last_i,
    output logic              hit_o,
    output logic [IDXW-1:0]   idx_o,
    output logic [N_INIT-1:0] onehot_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int k = 1; k <= N_INIT; k++) begin
            if (!hit_o && req_i[IDXW'((int'(last_i) + k) % N_INIT)]) begin
                hit_o = 1'b1;
                idx_o = IDXW'((int'(last_i) + k) % N_INIT);
            end
        end
    end

    generate
        for (genvar g = 0; g < N_INIT; g++) begin : g_dec
            assign onehot_o[g] = hit_o && (idx_o == IDXW'(g));
        end
    endgenerate

endmodule

// File: rtl/arb_bus_watch.sv
module arb_bus_watch (
    input  logic frame_i,
    input  logic irdy_i,
    input  logic idle_q_i,
    output logic idle_now_o,
    output logic start_o
);

    // idle clock: neither frame nor ready driven
    assign idle_now_o = !frame_i && !irdy_i;
    // a start needs an idle clock right before frame rises
    assign start_o    = frame_i && idle_q_i;

endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter #(
    parameter int N_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_INIT-1:0] req_i,
    input  logic              frame_i,
    input  logic              irdy_i,
    output logic [N_INIT-1:0] gnt_o
);
    import arb_pkg::*;

    localparam int IDXW = (N_INIT > 1) ? $clog2(N_INIT) : 1;
    localparam logic [IDXW-1:0] LAST_RST = IDXW'(N_INIT - 1);

    typedef struct packed {
        arb_phase_e        phase;
        logic [N_INIT-1:0] gnt;
        logic [IDXW-1:0]   owner;
        logic [IDXW-1:0]   last;
        logic              idle;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic              pick_hit;
    logic [IDXW-1:0]   pick_idx;
    logic [N_INIT-1:0] pick_onehot;
    logic              bus_idle_now;
    logic              bus_start;

    arb_rr_pick #(.N_INIT(N_INIT), .IDXW(IDXW)) u_pick (
        .req_i    (req_i),
        .last_i   (st_q.last),
        .hit_o    (pick_hit),
        .idx_o    (pick_idx),
        .onehot_o (pick_onehot)
    );

    arb_bus_watch u_watch (
        .frame_i    (frame_i),
        .irdy_i     (irdy_i),
        .idle_q_i   (st_q.idle),
        .idle_now_o (bus_idle_now),
        .start_o    (bus_start)
    );

    always_comb begin
        st_d      = st_q;
        st_d.idle = bus_idle_now;
        unique case (st_q.phase)
            PH_OPEN: begin
                if (pick_hit) begin
                    st_d.phase = PH_HELD;
                    st_d.gnt   = pick_onehot;
                    st_d.owner = pick_idx;
                end
            end
            PH_HELD: begin
                if (bus_start) begin
                    // grant consumed by the owner's transaction
                    st_d.phase = PH_OPEN;
                    st_d.gnt   = '0;
                    st_d.last  = st_q.owner;
                end else if (!req_i[st_q.owner]) begin
                    // unused grant withdrawn; rotation point kept
                    st_d.phase = PH_OPEN;
                    st_d.gnt   = '0;
                end
            end
            default: begin
                st_d.phase = PH_OPEN;
                st_d.gnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_OPEN;
            st_q.gnt   <= '0;
            st_q.owner <= '0;
            st_q.last  <= LAST_RST;
            st_q.idle  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = st_q.gnt;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N_INIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_INIT-1:0] req_i,
    input logic              frame_i,
    input logic              irdy_i,
    input logic [N_INIT-1:0] gnt_o
);

    logic quiet_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) quiet_seen <= 1'b1;
        else        quiet_seen <= !frame_i && !irdy_i;
    end

    always_comb begin
        if (!rst_n) AST_RESET_CLEAR: assert (gnt_o == '0); // R1
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R2

    AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (gnt_o == '0)); // R4

    AST_START_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && frame_i && quiet_seen) |=> (gnt_o == '0)); // R7

    AST_DROP_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && ((gnt_o & req_i) == '0)) |=> (gnt_o == '0)); // R9

    AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && ($past(gnt_o) != '0)) |-> (gnt_o == $past(gnt_o))); // R10

    generate
        for (genvar g = 0; g < N_INIT; g++) begin : g_req
            AST_REQ_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_o[g] |-> $past(req_i[g])); // R3
        end
    endgenerate

endmodule

bind bus_owner_arbiter arb_checker #(.N_INIT(N_INIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .frame_i (frame_i),
    .irdy_i  (irdy_i),
    .gnt_o   (gnt_o)
);

// File: tb/sim_bus_owner_arbiter.sv
module sim_bus_owner_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] req = '0;
    logic          frame = 1'b0;
    logic          irdy = 1'b0;
    logic [NI-1:0] gnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NI-1:0] exp_q[$];
    string         tag_q[$];

    bus_owner_arbiter #(.N_INIT(NI)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .frame_i (frame),
        .irdy_i  (irdy),
        .gnt_o   (gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // driver: apply one clock of stimulus and queue the grant expected after the edge
    task automatic step(input logic [NI-1:0] r, input logic f, input logic i,
                        input logic [NI-1:0] e, input string t);
        @(negedge clk);
        req = r; frame = f; irdy = i;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // monitor: compare each registered grant against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [NI-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (gnt !== e) begin
                    errors++;
                    $display("FAIL %s: gnt actual %b expected %b", t, gnt, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (gnt !== '0) begin
            errors++;
            $display("FAIL R1 in reset: actual %b expected 0000", gnt);
        end
        rst_n = 1'b1;
        // state now: last starter 3, bus idle
        step(4'b0000, 0, 0, 4'b0000, "R1/R4 no requests after reset");
        step(4'b0010, 0, 0, 4'b0010, "R3/R5 lone requester 1");
        step(4'b0010, 1, 0, 4'b0000, "R7 start by 1 drops grant");
        step(4'b1010, 1, 1, 4'b1000, "R6/R8 hidden grant to 3 while busy, not 1");
        step(4'b1010, 0, 1, 4'b1000, "R6 hold during final phase");
        step(4'b1010, 1, 0, 4'b1000, "R11 frame rise without idle clock");
        step(4'b1010, 0, 0, 4'b1000, "R11 hold through idle clock");
        step(4'b1010, 1, 0, 4'b0000, "R7 start by 3 drops grant");
        step(4'b1010, 1, 1, 4'b0010, "R5 rotate from 3 to 1");
        step(4'b1000, 1, 1, 4'b0000, "R9 request dropped withdraws grant");
        step(4'b1000, 0, 0, 4'b1000, "R9/R10 regrant to 3 after gap, last unchanged");
        step(4'b1000, 0, 0, 4'b1000, "R2 grant held steady");
        step(4'b0000, 0, 0, 4'b0000, "R4 requests gone");
        step(4'b1111, 0, 0, 4'b0001, "R5 all request, start at 0");
        step(4'b1111, 1, 0, 4'b0000, "R7 start by 0");
        step(4'b1111, 0, 1, 4'b0010, "R5/R10 next is 1");
        step(4'b1111, 0, 0, 4'b0010, "R2 hold 1");
        step(4'b1111, 1, 0, 4'b0000, "R7 start by 1");
        step(4'b1111, 0, 0, 4'b0100, "R5 next is 2");
        step(4'b1111, 1, 0, 4'b0000, "R7 start by 2");
        step(4'b1111, 0, 0, 4'b1000, "R5 next is 3");
        step(4'b1111, 1, 0, 4'b0000, "R7 start by 3");
        step(4'b1111, 0, 0, 4'b0001, "R5 wrap back to 0");
        step(4'b0000, 0, 0, 4'b0000, "R4/R9 all requests dropped");
        step(4'b0000, 0, 0, 4'b0000, "R4 stays idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule